// File: doc/BRIEF.md
# Feed-forward input voltage conditioner

This block produces the feed-forward duty term for the compensator of a digital power converter. It builds an input-voltage estimate from one of four sources: two fast secondary-side rectified-voltage samples, a slow primary-side sample, and a word written by firmware. Each source is scaled according to where it was measured. The block also forms the output-voltage target from the internal reference and a stored reciprocal of the output divider ratio. It then divides the target by the conditioned input voltage to give an unsigned Q1.15 duty value.

The two fast channels and the firmware word share one number format and are scaled by the rectifier divider factor. The second fast channel carries the phase-two rectified voltage in single-loop interleaved operation. The slow primary channel first passes through a first-order low-pass filter with a programmable gain. It is then scaled by the transformer turns-ratio factor.

A computation runs only when it is requested with a start pulse. The source and all operands are captured at that point, so register writes made while the division runs do not affect it.

Top module: `ffd_vin_path`

## Requirements
- R1: After reset, `duty`, `vin_used` and `pri_filt` are zero, and `busy` and `done` are low.
- R2: `src_sel` picks the source at the edge that accepts `start`: 0 selects `rect_a`, 1 selects `rect_b`, 2 selects the filtered primary value `pri_filt`, and 3 selects `fw_vin`. The scaled result appears on `vin_used`.
- R3: The sources selected by 0, 1 and 3 are multiplied by `rect_scale`, an unsigned Q2.14 value. The product is shifted right by 14 and saturates to 0xFFFF when it exceeds 16 bits.
- R4: The filtered primary value is multiplied by `turns_scale`, an unsigned Q2.14 value. The same truncation and saturation as in R3 apply.
- R5: On each clock edge where `pri_valid` is high, `pri_filt` becomes y + floor(((x − y)·k) / 65536), where x is `pri_sample`, y is the previous `pri_filt` and k is `lpf_gain`. Without `pri_valid`, `pri_filt` holds its value.
- R6: The target is `vref`·`inv_vout_scale` shifted right by 14, with `inv_vout_scale` an unsigned Q2.14 value. It saturates to 0xFFFF.
- R7: `duty` equals floor(target·32768 / `vin_used`), saturated to 0xFFFF. A `vin_used` of zero gives 0xFFFF.
- R8: `done` is a one-cycle pulse. It rises at the 31st clock edge after the edge that accepts `start`, or at the accepting edge itself when `vin_used` is zero. `duty` is valid while `done` is high and holds until the next completion.
- R9: A `start` seen while `busy` is high is ignored. Changes to `src_sel`, the sources or the scale factors during a computation do not alter its result or its timing.
- R10: `busy` is high from the accepting edge until the edge that raises `done`, and `busy` and `done` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a new computation (accepted when idle) |
| src_sel | input | 2 | Source choice: 0 rect_a, 1 rect_b, 2 primary, 3 firmware |
| rect_a | input | 16 | First rectified-voltage sample |
| rect_b | input | 16 | Phase-two rectified-voltage sample |
| pri_sample | input | 16 | Slow primary-side sample |
| pri_valid | input | 1 | Strobe marking a new primary sample |
| fw_vin | input | 16 | Firmware override word, fast-sample format |
| rect_scale | input | 16 | Rectifier divider factor, Q2.14 |
| turns_scale | input | 16 | Transformer turns-ratio factor, Q2.14 |
| lpf_gain | input | 16 | Low-pass filter gain, k/65536 |
| vref | input | 16 | Internal control reference |
| inv_vout_scale | input | 16 | Reciprocal of the output divider ratio, Q2.14 |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse |
| duty | output | 16 | Feed-forward duty, unsigned Q1.15 |
| vin_used | output | 16 | Scaled input voltage captured for the current result |
| pri_filt | output | 16 | Low-pass filter state of the primary channel |

## Verification
The assertions check several properties on every cycle: the filter holds without a strobe and moves only toward the new sample, `busy` and `done` exclude each other, `done` does not repeat without a new request, a zero divisor saturates at once, and the captured divisor stays fixed while a division runs. Only the bench scenarios can show that the quotient and the scaled values are numerically correct for each source. The same holds for the exact 31-edge latency and for the rule that source and operand changes made mid-computation are ignored.

// File: rtl/ffd_pkg.sv
package ffd_pkg;
    typedef enum logic [1:0] {
        SRC_RECT_A = 2'd0,
        SRC_RECT_B = 2'd1,
        SRC_PRI    = 2'd2,
        SRC_FW     = 2'd3
    } ffd_src_e;
endpackage

// File: rtl/ffd_lpf.sv
module ffd_lpf #(
    parameter int W  = 16,
    parameter int SH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         valid,
    input  logic [W-1:0] sample,
    input  logic [W-1:0] gain,
    output logic [W-1:0] y
);
    localparam int PW = 2 * W + 2;

    typedef struct packed {
        logic [W-1:0] acc;
    } lpf_st_t;

    lpf_st_t st_d, st_q;
    logic signed [W:0]    err;
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] step;
    logic signed [PW-1:0] sum;

    always_comb begin
        st_d = st_q;
        err  = $signed({1'b0, sample}) - $signed({1'b0, st_q.acc});
        prod = PW'(err) * PW'($signed({1'b0, gain}));
        step = prod >>> SH;
        sum  = $signed({{(PW-W){1'b0}}, st_q.acc}) + step;
        if (valid) begin
            st_d.acc = sum[W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign y = st_q.acc;

    a_r5_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> $stable(y));
    a_r5_moves_toward_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && sample >= y) |=> (y >= $past(y) && y <= $past(sample)));
    a_r5_moves_toward_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && sample < y) |=> (y <= $past(y) && y >= $past(sample)));
endmodule

// File: rtl/ffd_scale.sv
module ffd_scale #(
    parameter int W    = 16,
    parameter int FRAC = 14
) (
    input  logic [W-1:0] value,
    input  logic [W-1:0] factor,
    output logic [W-1:0] scaled
);
    localparam int PW = 2 * W;

    logic [PW-1:0] prod;
    logic [PW-1:0] shifted;

    always_comb begin
        prod    = PW'(value) * PW'(factor);
        shifted = prod >> FRAC;
        scaled  = (|shifted[PW-1:W]) ? {W{1'b1}} : shifted[W-1:0];
    end
endmodule

// File: rtl/ffd_divider.sv
module ffd_divider #(
    parameter int W  = 16,
    parameter int QF = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] result,
    output logic [W-1:0] divisor_held
);
    localparam int DW = W + QF;
    localparam int CW = $clog2(DW);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic [CW-1:0] cnt;
        logic [DW-1:0] dvd;
        logic [W-1:0]  rem;
        logic [DW-1:0] quo;
        logic [W-1:0]  dvs;
        logic [W-1:0]  res;
    } div_st_t;

    div_st_t st_d, st_q;
    logic [W:0]    rem_sh;
    logic [W:0]    rem_sub;
    logic          qbit;
    logic [DW-1:0] quo_nx;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        rem_sh    = {st_q.rem, st_q.dvd[DW-1]};
        rem_sub   = rem_sh - {1'b0, st_q.dvs};
        qbit      = (rem_sh >= {1'b0, st_q.dvs});
        quo_nx    = {st_q.quo[DW-2:0], qbit};
        if (!st_q.busy) begin
            if (start) begin
                st_d.dvs = divisor;
                if (divisor == '0) begin
                    st_d.done = 1'b1;
                    st_d.res  = {W{1'b1}};
                end else begin
                    st_d.busy = 1'b1;
                    st_d.cnt  = '0;
                    st_d.dvd  = {dividend, {QF{1'b0}}};
                    st_d.rem  = '0;
                    st_d.quo  = '0;
                end
            end
        end else begin
            st_d.dvd = st_q.dvd << 1;
            st_d.rem = qbit ? rem_sub[W-1:0] : rem_sh[W-1:0];
            st_d.quo = quo_nx;
            if (st_q.cnt == CW'(DW - 1)) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.res  = (|quo_nx[DW-1:W]) ? {W{1'b1}} : quo_nx[W-1:0];
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy         = st_q.busy;
    assign done         = st_q.done;
    assign result       = st_q.res;
    assign divisor_held = st_q.dvs;

    a_r10_busy_done_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    a_r8_done_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !done);
    a_r7_zero_divisor_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && divisor == '0) |=> (done && result == {W{1'b1}}));
    a_r9_divisor_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(divisor_held));
endmodule

// File: rtl/ffd_vin_path.sv
module ffd_vin_path #(
    parameter int W    = 16,
    parameter int FRAC = 14,
    parameter int QF   = 15,
    parameter int LPSH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    src_sel,
    input  logic [W-1:0]  rect_a,
    input  logic [W-1:0]  rect_b,
    input  logic [W-1:0]  pri_sample,
    input  logic          pri_valid,
    input  logic [W-1:0]  fw_vin,
    input  logic [W-1:0]  rect_scale,
    input  logic [W-1:0]  turns_scale,
    input  logic [W-1:0]  lpf_gain,
    input  logic [W-1:0]  vref,
    input  logic [W-1:0]  inv_vout_scale,
    output logic          busy,
    output logic          done,
    output logic [W-1:0]  duty,
    output logic [W-1:0]  vin_used,
    output logic [W-1:0]  pri_filt
);
    import ffd_pkg::*;

    ffd_src_e     sel;
    logic [W-1:0] raw_vin;
    logic [W-1:0] vin_factor;
    logic [W-1:0] vin_scaled;
    logic [W-1:0] target;

    ffd_lpf #(.W(W), .SH(LPSH)) u_lpf (
        .clk    (clk),
        .rst_n  (rst_n),
        .valid  (pri_valid),
        .sample (pri_sample),
        .gain   (lpf_gain),
        .y      (pri_filt)
    );

    always_comb begin
        sel        = ffd_src_e'(src_sel);
        vin_factor = rect_scale;
        unique case (sel)
            SRC_RECT_A: raw_vin = rect_a;
            SRC_RECT_B: raw_vin = rect_b;
            SRC_PRI: begin
                raw_vin    = pri_filt;
                vin_factor = turns_scale;
            end
            default:    raw_vin = fw_vin;
        endcase
    end

    ffd_scale #(.W(W), .FRAC(FRAC)) u_vin_scale (
        .value  (raw_vin),
        .factor (vin_factor),
        .scaled (vin_scaled)
    );

    ffd_scale #(.W(W), .FRAC(FRAC)) u_tgt_scale (
        .value  (vref),
        .factor (inv_vout_scale),
        .scaled (target)
    );

    ffd_divider #(.W(W), .QF(QF)) u_div (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .dividend     (target),
        .divisor      (vin_scaled),
        .busy         (busy),
        .done         (done),
        .result       (duty),
        .divisor_held (vin_used)
    );
endmodule

// File: tb/tb_ffd_vin_path.sv
`timescale 1ns/1ps
module tb_ffd_vin_path;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  src_sel = 2'd0;
    logic [15:0] rect_a = '0, rect_b = '0, pri_sample = '0, fw_vin = '0;
    logic        pri_valid = 1'b0;
    logic [15:0] rect_scale = 16'h4000, turns_scale = 16'h4000, lpf_gain = '0;
    logic [15:0] vref = '0, inv_vout_scale = 16'h4000;
    logic        busy, done;
    logic [15:0] duty, vin_used, pri_filt;

    int errors = 0;
    int checks = 0;
    longint filt_m = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    ffd_vin_path dut (
        .clk(clk), .rst_n(rst_n), .start(start), .src_sel(src_sel),
        .rect_a(rect_a), .rect_b(rect_b), .pri_sample(pri_sample), .pri_valid(pri_valid),
        .fw_vin(fw_vin), .rect_scale(rect_scale), .turns_scale(turns_scale),
        .lpf_gain(lpf_gain), .vref(vref), .inv_vout_scale(inv_vout_scale),
        .busy(busy), .done(done), .duty(duty), .vin_used(vin_used), .pri_filt(pri_filt)
    );

    function automatic longint scale_m(longint x, longint k);
        longint p = (x * k) >> 14;
        return (p > 65535) ? 65535 : p;
    endfunction

    function automatic longint duty_m(longint t, longint v);
        longint q;
        if (v == 0) return 65535;
        q = (t << 15) / v;
        return (q > 65535) ? 65535 : q;
    endfunction

    function automatic longint vin_m();
        case (src_sel)
            2'd0: return scale_m(rect_a, rect_scale);
            2'd1: return scale_m(rect_b, rect_scale);
            2'd2: return scale_m(filt_m, turns_scale);
            default: return scale_m(fw_vin, rect_scale);
        endcase
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
                finish_run();
            end
        end
    end

    task automatic lpf_pulse(input logic [15:0] x, input logic [15:0] k);
        longint d;
        @(negedge clk);
        pri_sample = x; lpf_gain = k; pri_valid = 1'b1;
        @(negedge clk);
        pri_valid = 1'b0;
        d = longint'(x) - filt_m;
        filt_m = filt_m + ((d * longint'(k)) >>> 16);
        check("R5 filter update", pri_filt, filt_m);
    endtask

    // Launch a computation; optionally disturb sources and re-request mid-run (R9)
    task automatic run_calc(input bit disturb, input string tag);
        longint ev, et, ed;
        int n;
        int exp_n;
        ev = vin_m();
        et = scale_m(vref, inv_vout_scale);
        ed = duty_m(et, ev);
        exp_n = (ev == 0) ? 1 : 32;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        if (exp_n > 1) check({tag, " R10 busy after accept"}, busy, 1);
        while (!done && n < 100) begin
            @(negedge clk);
            n++;
            if (disturb && n == 3) begin
                src_sel = 2'($urandom); rect_a = 16'($urandom); rect_b = 16'($urandom);
                fw_vin = 16'($urandom); rect_scale = 16'($urandom); vref = 16'($urandom);
                start = 1'b1;
            end
            if (disturb && n == 4) start = 1'b0;
        end
        check({tag, " R8 latency"}, n, exp_n);
        check({tag, " R10 busy low at done"}, busy, 0);
        check({tag, " R2 vin_used"}, vin_used, ev);
        check({tag, " R7 duty"}, duty, ed);
        @(negedge clk);
        check({tag, " R8 done pulse width"}, done, 0);
        check({tag, " R8 duty holds"}, duty, ed);
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(2024);
        #1;
        check("R1 reset duty", duty, 0);
        check("R1 reset vin_used", vin_used, 0);
        check("R1 reset pri_filt", pri_filt, 0);
        check("R1 reset busy", busy, 0);
        check("R1 reset done", done, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2/R3 directed: each fast source and firmware word with unity and 2x scale
        vref = 16'd10000; inv_vout_scale = 16'h4000;
        rect_a = 16'd20000; rect_b = 16'd5000; fw_vin = 16'd40000; rect_scale = 16'h4000;
        src_sel = 2'd0; run_calc(0, "R3 rect_a");
        src_sel = 2'd1; run_calc(0, "R3 rect_b");
        src_sel = 2'd3; run_calc(0, "R3 fw");
        rect_scale = 16'h8000; src_sel = 2'd3; run_calc(0, "R3 fw saturating");

        // R5 filter and R4 primary path
        lpf_pulse(16'd30000, 16'h8000);
        lpf_pulse(16'd30000, 16'h4000);
        lpf_pulse(16'd1000, 16'hFFFF);
        @(negedge clk); pri_sample = 16'd60000;
        repeat (3) @(negedge clk);
        check("R5 hold without strobe", pri_filt, filt_m);
        turns_scale = 16'h6000; src_sel = 2'd2; run_calc(0, "R4 primary");

        // R6/R7 saturation corners
        rect_scale = 16'h4000; src_sel = 2'd0;
        rect_a = 16'd0; run_calc(0, "R7 zero divisor");
        rect_a = 16'd1; vref = 16'hFFFF; inv_vout_scale = 16'hFFFF; run_calc(0, "R6 big target");
        rect_a = 16'd40000; vref = 16'd40000; inv_vout_scale = 16'h4000; run_calc(0, "R7 unity");

        // R9: disturbance during a run
        rect_a = 16'd12345; vref = 16'd7777; src_sel = 2'd0; run_calc(1, "R9 disturb");

        // Random mix
        for (int i = 0; i < 60; i++) begin
            src_sel = 2'($urandom);
            rect_a = 16'($urandom); rect_b = 16'($urandom); fw_vin = 16'($urandom);
            rect_scale = 16'($urandom_range(32768, 4096));
            turns_scale = 16'($urandom_range(65535, 1024));
            vref = 16'($urandom_range(20000, 0));
            inv_vout_scale = 16'($urandom_range(32768, 8192));
            if (($urandom % 3) == 0) lpf_pulse(16'($urandom), 16'($urandom));
            run_calc(i % 7 == 3, "R2 random");
        end
        finish_run();
    end
endmodule